// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block drives a small set of programmable clock outputs. Each output picks one of five source clocks (slow, main, master, PLL A, USB PLL) and divides it by a power of two from 1 to 64. A system-clock register port enables and disables outputs with write-one-to-set and write-one-to-clear registers. Each output also has a configuration word that holds its source and its prescaler together. Once a divided clock has run for a fixed number of source edges, a per-output ready bit is raised, and that bit can drive a shared, maskable interrupt.

All logic runs in the system clock domain. Each source clock is brought in through a two-flop synchroniser and edge detector, and every output is a register. An output therefore cannot glitch. Source clocks must run slower than half the system clock.

Each output is controlled by a four-state machine. OFF holds the output low and clears the divider. When the enable bit is set, OFF goes to SYNC. In SYNC the divider runs and SYNC_EDGES rising edges of the selected source are counted; after the last one SYNC goes to RUN, where the ready bit is high. When the enable bit is cleared, SYNC or RUN goes to OFF if the output is low, or to DRAIN if it is high. DRAIN lets the current high phase finish at its normal length and then goes to OFF. Any state outside OFF only goes back to SYNC by passing through OFF.

Top module: `pck_gen`

## Requirements
- R1: After reset every output is disabled and held low, all ready and interrupt-mask bits are 0, `irq_o` is 0, and every configuration word reads 0 (slow clock, ratio 1).
- R2: Configuration word fields: bits [1:0] select the source (0 slow, 1 main, 2 PLL A, 3 USB PLL), and bit 8 set selects the master clock instead. Bits [4:2] hold exponent p, and the output period is the source period times 2^p. Value 0x15 gives main clock divided by 32.
- R3: Exponent value 7 is reserved and divides by 1.
- R4: Writing address 0 sets enable bits and writing address 1 clears them; only bits written as one change. Address 2 reads the enable bits.
- R5: A configuration write to address 8+n is ignored unless output n is disabled and in OFF; the word reads back unchanged.
- R6: Ready bit n (address 3) is 0 directly after enable and rises after SYNC_EDGES rising edges of the selected source. It is 0 from the cycle after the enable bit clears.
- R7: A disabled output is low. On disable, a high phase in progress finishes at its normal length, after which the output stays low.
- R8: `irq_o` is the OR over outputs of ready AND mask. Address 4 sets mask bits, address 5 clears them, and address 6 reads them.
- R9: After a disable, reconfiguration and re-enable, the output runs at the new ratio and ready qualifies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | 5 | Source clocks: [0] slow, [1] main, [2] master, [3] PLL A, [4] USB PLL |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Read data (combinational) |
| pck_o | output | NOUT | Programmable clock outputs |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check these rules on every cycle:
- a low, disabled output stays low;
- an output in DRAIN never rises;
- ready drops in the cycle after the enable bit clears;
- configuration words stay frozen while an output is busy;
- a written set bit lands in the enable register;
- with no mask bit set there is no interrupt.

The following can only be shown by the bench scenarios:
- output periods for each source and ratio, including the reserved exponent;
- the length of the final high phase after a disable;
- how long ready takes to qualify;
- interrupt masking as outputs come and go.

// File: rtl/pck_pkg.sv
package pck_pkg;
    localparam int NSRC     = 5;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int DIVW     = 6;

    localparam logic [ADDR_W-1:0] A_EN_SET   = 4'd0;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 4'd1;
    localparam logic [ADDR_W-1:0] A_EN_STAT  = 4'd2;
    localparam logic [ADDR_W-1:0] A_READY    = 4'd3;
    localparam logic [ADDR_W-1:0] A_IE_SET   = 4'd4;
    localparam logic [ADDR_W-1:0] A_IE_CLR   = 4'd5;
    localparam logic [ADDR_W-1:0] A_IE_MASK  = 4'd6;
    localparam logic [ADDR_W-1:0] A_CFG_BASE = 4'd8;

    typedef struct packed {
        logic       mstr;
        logic [2:0] pres;
        logic [1:0] css;
    } cfg_t;

    typedef enum logic [1:0] {ST_OFF, ST_SYNC, ST_RUN, ST_DRAIN} ch_state_e;

    function automatic logic [2:0] src_index(input cfg_t c);
        if (c.mstr) return 3'd2;
        unique case (c.css)
            2'd0: return 3'd0;
            2'd1: return 3'd1;
            2'd2: return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] eff_exp(input cfg_t c);
        return (c.pres == 3'd7) ? 3'd0 : c.pres;
    endfunction
endpackage

// File: rtl/pck_srcsync.sv
module pck_srcsync
    import pck_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk_i,
    output logic [NSRC-1:0] lvl_o,
    output logic [NSRC-1:0] rise_o
);
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic [2:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[1:0], src_clk_i[s]};
        end
        assign lvl_o[s]  = sh[1];
        assign rise_o[s] = sh[1] & ~sh[2];
    end
endmodule

// File: rtl/pck_channel.sv
module pck_channel
    import pck_pkg::*;
#(
    parameter int SYNC_EDGES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  cfg_t            cfg_i,
    input  logic [NSRC-1:0] src_lvl_i,
    input  logic [NSRC-1:0] src_rise_i,
    output logic            out_o,
    output logic            ready_o,
    output logic            idle_o
);
    localparam int SCW = $clog2(SYNC_EDGES + 1);

    ch_state_e       state, state_nx;
    logic            out_q, out_nx;
    logic [DIVW-1:0] cnt, cnt_nx, half_m1;
    logic [SCW-1:0]  sync_cnt;
    logic [2:0]      sel, pexp;
    logic            lvl, rise;

    assign sel  = src_index(cfg_i);
    assign pexp = eff_exp(cfg_i);
    assign lvl  = src_lvl_i[sel];
    assign rise = src_rise_i[sel];
    assign half_m1 = (pexp == 3'd0) ? '0
                   : (DIVW'(1) << (3'(pexp - 3'd1))) - DIVW'(1);

    // divider step shared by running and draining states
    always_comb begin
        if (pexp == 3'd0) begin
            out_nx = lvl;
            cnt_nx = '0;
        end else if (rise) begin
            out_nx = (cnt == half_m1) ? ~out_q : out_q;
            cnt_nx = (cnt == half_m1) ? '0 : cnt + DIVW'(1);
        end else begin
            out_nx = out_q;
            cnt_nx = cnt;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (en_i) state_nx = ST_SYNC;
            ST_SYNC:  if (!en_i) state_nx = out_q ? ST_DRAIN : ST_OFF;
                      else if (rise && sync_cnt == SCW'(SYNC_EDGES - 1)) state_nx = ST_RUN;
            ST_RUN:   if (!en_i) state_nx = out_q ? ST_DRAIN : ST_OFF;
            ST_DRAIN: if (!out_q) state_nx = ST_OFF;
            default:  state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q    <= 1'b0;
            cnt      <= '0;
            sync_cnt <= '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    out_q    <= 1'b0;
                    cnt      <= '0;
                    sync_cnt <= '0;
                end
                ST_SYNC, ST_RUN: begin
                    cnt   <= cnt_nx;
                    out_q <= en_i ? out_nx : (out_q & out_nx);
                    if (state == ST_SYNC && rise) sync_cnt <= sync_cnt + SCW'(1);
                end
                default: begin
                    cnt   <= cnt_nx;
                    out_q <= out_q & out_nx;
                end
            endcase
        end
    end

    assign out_o   = out_q;
    assign ready_o = (state == ST_RUN);
    assign idle_o  = (state == ST_OFF);

    // R7
    gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !out_q) |=> !out_q);
    // R7
    no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> !$rose(out_q));
    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !ready_o);
endmodule

// File: rtl/pck_regs.sv
module pck_regs
    import pck_pkg::*;
#(
    parameter int NOUT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [NOUT-1:0]   idle_i,
    input  logic [NOUT-1:0]   ready_i,
    output logic [NOUT-1:0]   en_o,
    output logic [NOUT-1:0]   mask_o,
    output cfg_t [NOUT-1:0]   cfg_o
);
    logic [NOUT-1:0] en_q, mask_q;
    cfg_t [NOUT-1:0] cfg_q;
    logic            wr_set, wr_clr, ie_set, ie_clr;

    assign wr_set = wr_en_i && (wr_addr_i == A_EN_SET);
    assign wr_clr = wr_en_i && (wr_addr_i == A_EN_CLR);
    assign ie_set = wr_en_i && (wr_addr_i == A_IE_SET);
    assign ie_clr = wr_en_i && (wr_addr_i == A_IE_CLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            if (wr_set) en_q <= en_q | wr_data_i[NOUT-1:0];
            if (wr_clr) en_q <= en_q & ~wr_data_i[NOUT-1:0];
            if (ie_set) mask_q <= mask_q | wr_data_i[NOUT-1:0];
            if (ie_clr) mask_q <= mask_q & ~wr_data_i[NOUT-1:0];
        end
    end

    for (genvar n = 0; n < NOUT; n++) begin : g_cfg
        logic hit;
        assign hit = wr_en_i && (wr_addr_i == A_CFG_BASE + ADDR_W'(n));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_q[n] <= '0;
            else if (hit && !en_q[n] && idle_i[n])
                cfg_q[n] <= '{mstr: wr_data_i[8], pres: wr_data_i[4:2], css: wr_data_i[1:0]};
        end

        // R5
        cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[n] || !idle_i[n]) |=> $stable(cfg_q[n]));
        // R4
        en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_set && wr_data_i[n]) |=> en_q[n]);
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            A_EN_STAT: rd_data_o[NOUT-1:0] = en_q;
            A_READY:   rd_data_o[NOUT-1:0] = ready_i;
            A_IE_MASK: rd_data_o[NOUT-1:0] = mask_q;
            default: begin
                for (int n = 0; n < NOUT; n++) begin
                    if (rd_addr_i == A_CFG_BASE + ADDR_W'(n)) begin
                        rd_data_o[8]   = cfg_q[n].mstr;
                        rd_data_o[4:2] = cfg_q[n].pres;
                        rd_data_o[1:0] = cfg_q[n].css;
                    end
                end
            end
        endcase
    end

    assign en_o   = en_q;
    assign mask_o = mask_q;
    assign cfg_o  = cfg_q;
endmodule

// File: rtl/pck_gen.sv
module pck_gen
    import pck_pkg::*;
#(
    parameter int NOUT       = 3,
    parameter int SYNC_EDGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_clk_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [NOUT-1:0]   pck_o,
    output logic              irq_o
);
    logic [NSRC-1:0] src_lvl, src_rise;
    logic [NOUT-1:0] en, mask, ready, idle;
    cfg_t [NOUT-1:0] cfg;

    pck_srcsync u_sync (
        .clk(clk), .rst_n(rst_n), .src_clk_i(src_clk_i),
        .lvl_o(src_lvl), .rise_o(src_rise)
    );

    pck_regs #(.NOUT(NOUT)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .idle_i(idle), .ready_i(ready),
        .en_o(en), .mask_o(mask), .cfg_o(cfg)
    );

    for (genvar n = 0; n < NOUT; n++) begin : g_ch
        pck_channel #(.SYNC_EDGES(SYNC_EDGES)) u_ch (
            .clk(clk), .rst_n(rst_n), .en_i(en[n]), .cfg_i(cfg[n]),
            .src_lvl_i(src_lvl), .src_rise_i(src_rise),
            .out_o(pck_o[n]), .ready_o(ready[n]), .idle_o(idle[n])
        );
    end

    assign irq_o = |(ready & mask);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);
endmodule

// File: tb/pck_gen_bench.sv
module pck_gen_bench;
    localparam int NOUT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [NOUT-1:0] pck;
    logic        irq;

    int tests = 0, fails = 0, cyc = 0, mon_ch = 0;
    int exp_q[$];
    string tag_q[$];
    bit done = 0;

    pck_gen #(.NOUT(NOUT), .SYNC_EDGES(4)) u_pck_gen (
        .clk(clk), .rst_n(rst_n), .src_clk_i(src),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .pck_o(pck), .irq_o(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // source periods in system cycles: slow 16, main 6, master 4, plla 5, upll 7
    initial begin #2; forever #80 src[0] = ~src[0]; end
    initial begin #2; forever #30 src[1] = ~src[1]; end
    initial begin #2; forever #20 src[2] = ~src[2]; end
    initial begin #2; forever #25 src[3] = ~src[3]; end
    initial begin #2; forever #35 src[4] = ~src[4]; end

    task automatic check(string req, int got, int expv);
        tests++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    // wait for ready bit ch; check it is low right after enable and within bounds
    task automatic wait_ready(int ch, int per, string req);
        int v, n;
        n = 0;
        rd(4'd3, v);
        check({req, " ready low after enable"}, (v >> ch) & 1, 0);
        do begin rd(4'd3, v); n++; end while (((v >> ch) & 1) == 0 && n < 2000);
        check({req, " ready delay in window"},
              int'(n >= 3*per && n <= 5*per + 8), 1);
    endtask

    task automatic expect_period(int ch, int per, string req);
        mon_ch = ch;
        exp_q.push_back(per);
        tag_q.push_back(req);
        wait (exp_q.size() == 0);
    endtask

    // scoreboard monitor: period between two rising edges of pck[mon_ch]
    initial begin
        int t0, p, e;
        string t;
        forever begin
            wait (exp_q.size() > 0);
            @(negedge clk); while (pck[mon_ch] != 0) @(negedge clk);
            while (pck[mon_ch] != 1) @(negedge clk);
            t0 = cyc;
            while (pck[mon_ch] != 0) @(negedge clk);
            while (pck[mon_ch] != 1) @(negedge clk);
            p = cyc - t0;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " period"}, p, e);
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v, t0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd2, v); check("R1 enable status", v, 0);
        rd(4'd3, v); check("R1 ready", v, 0);
        rd(4'd6, v); check("R1 mask", v, 0);
        rd(4'd8, v); check("R1 cfg0", v, 0);
        repeat (40) @(negedge clk);
        check("R1 outputs low", int'(pck), 0);
        check("R1 irq low", int'(irq), 0);

        // R4 set ch0, default slow /1 (R2)
        wr(4'd0, 32'h1);
        rd(4'd2, v); check("R4 enable status after set", v, 1);
        wait_ready(0, 16, "R6 ch0");
        expect_period(0, 16, "R2 ch0 slow/1");

        // R2 0x15 = main/32 on ch1
        wr(4'd9, 32'h15);
        rd(4'd9, v); check("R2 cfg1 readback", v, 32'h15);
        wr(4'd0, 32'h2);
        rd(4'd2, v); check("R4 enable status both", v, 3);
        wait_ready(1, 6, "R6 ch1");
        expect_period(1, 192, "R2 ch1 main/32");

        // R4 clear only ch0
        wr(4'd1, 32'h1);
        rd(4'd2, v); check("R4 clear leaves ch1", v, 2);
        repeat (40) @(negedge clk);
        check("R7 ch0 low when disabled", int'(pck[0]), 0);

        // R5 config write while enabled ignored
        wr(4'd9, 32'h0);
        rd(4'd9, v); check("R5 cfg1 unchanged", v, 32'h15);
        expect_period(1, 192, "R5 ch1 ratio kept");

        // R7 drain: disable mid high phase, high lasts full half period
        @(negedge clk); while (pck[1] != 0) @(negedge clk);
        while (pck[1] != 1) @(negedge clk);
        t0 = cyc;
        repeat (10) @(negedge clk);
        wr(4'd1, 32'h2);
        rd(4'd3, v); check("R6 ready clears on disable", (v >> 1) & 1, 0);
        while (pck[1] != 0) @(negedge clk);
        check("R7 final high phase length", cyc - t0, 96);
        v = 0;
        repeat (300) begin @(negedge clk); if (pck[1]) v = 1; end
        check("R7 stays low after drain", v, 0);

        // R9 reconfigure ch1 to master /8 and re-enable
        wr(4'd9, 32'h10C);
        rd(4'd9, v); check("R9 cfg1 new value", v, 32'h10C);
        wr(4'd0, 32'h2);
        wait_ready(1, 4, "R9 ch1");
        expect_period(1, 32, "R9 ch1 master/8");

        // R3 reserved exponent 7 on USB PLL
        wr(4'd10, 32'h1F);
        wr(4'd0, 32'h4);
        wait_ready(2, 7, "R3 ch2");
        expect_period(2, 7, "R3 ch2 upll reserved /1");

        // R2 PLL A /64 on ch0
        wr(4'd8, 32'h1A);
        rd(4'd8, v); check("R2 cfg0 accepted when idle", v, 32'h1A);
        // R8 interrupts
        wr(4'd4, 32'h4);
        rd(4'd6, v); check("R8 mask readback", v, 4);
        @(negedge clk); check("R8 irq with ready ch2", int'(irq), 1);
        wr(4'd5, 32'h4);
        @(negedge clk); check("R8 irq masked", int'(irq), 0);
        wr(4'd4, 32'h1);
        @(negedge clk); check("R8 irq off while ch0 not ready", int'(irq), 0);
        wr(4'd0, 32'h1);
        wait_ready(0, 5, "R6 ch0 plla");
        @(negedge clk); check("R8 irq when ch0 ready", int'(irq), 1);
        expect_period(0, 320, "R2 ch0 plla/64");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule